// File: doc/BRIEF.md
# Gauge register slave with alert response

This block is the serial-bus side of a measurement device. It is a two-wire (I2C/SMBus) slave, sampled by a faster system clock. The host sees sixteen byte-wide registers. A write sets an internal pointer, and any further bytes are stored at that pointer as it steps forward. A read continues from the pointer after a repeated start and returns consecutive registers while the master keeps acknowledging. The measurement logic sits beside the block. It loads results through a plain write port, raises per-bit status conditions, and reads back the control byte.

The block owns the status register. A status bit sets while its condition input is high and stays set until the host reads it. At that read it clears, unless its condition is still present. A status bit going from 0 to 1 is an alert event. An alert event drives the open-drain alert line low, provided the control byte selects alert pin mode. The line is released only by an alert response. In that exchange the master reads from address 0001100 and the block returns its own address followed by a 1. The block backs off if another device wins the bit-wise arbitration on SDA.

Top module: `i2c_gauge_slave`

## Requirements
- R1: A START followed by address byte 1100100 plus a direction bit is acknowledged by pulling SDA low in the ninth clock. Any other address, apart from a valid alert response, leaves SDA released.
- R2: In a write, the first byte after the address loads the 4-bit pointer from its low nibble. Each later byte is stored at the pointer, which then advances and wraps from 15 to 0.
- R3: After a repeated START with the read address, the slave sends the register at the pointer, MSB first. Each master ACK advances the pointer and sends the next register. A master NAK ends the read with SDA released.
- R4: After reset, the registers hold these values: index 1 (control) 3Ch, 2 and 3 (charge) 7Fh and FFh, indices 4, 5, 10 and 14 FFh, and all others 00h.
- R5: Host writes to indices 0, 8, 9, 12 and 13 are ignored. Only the measurement port can load indices 8, 9, 12 and 13.
- R6: Index 0 reads as {2'b00, status[5:0]}. A status bit sets while its condition input is high and stays set until cleared.
- R7: When a read loads index 0 for sending, each status bit whose condition is low clears. Bits whose condition is still high stay set.
- R8: A 0-to-1 status transition marks an alert pending. The alert output is pulled only while an alert is pending and control bits [2:1] equal 2'b10.
- R9: While the alert output is pulled, a read from 0001100 is acknowledged and answered with byte C9h (1100100 followed by 1). After that byte the pending alert is dropped.
- R10: If the slave releases SDA for a 1 during the alert reply but samples SDA low at SCL rise, it stops driving at once and the alert stays pending.
- R11: A read from 0001100 while the alert output is not pulled is not acknowledged.
- R12: SDA is only ever pulled low. A STOP returns the slave to idle with SDA released, and a START or repeated START restarts address reception from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| alert_pull_o | output | 1 | 1 pulls the alert line low |
| stat_cond_i | input | 6 | Status condition levels, bit i feeds status bit i |
| meas_we_i | input | 1 | Measurement port write strobe |
| meas_addr_i | input | 4 | Measurement port register index |
| meas_data_i | input | 8 | Measurement port write data |
| ctrl_o | output | 8 | Current control register value |

## Verification
The bench builds the block with its default parameters: a two-stage line synchroniser, slave address 64h, alert response address 0Ch and control reset value 3Ch. The SCL quarter period is five system clocks. This leaves room for the synchroniser and edge-detect latency before every SDA sample. With these values the bench can cross the pointer wrap, exercise the protected indices and drive the alert line through both a won and a lost arbitration. An extra open-drain driver on the bench side plays the competing device.

// File: rtl/gg_pkg.sv
package gg_pkg;
   localparam int NREG   = 16;
   localparam int IDX_W  = 4;
   localparam int STAT_W = 6;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_RXD, ST_ACK, ST_TX, ST_MACK
   } gg_state_e;

   function automatic logic [7:0] reg_rst_val(input int idx, input logic [7:0] ctrl_rst);
      case (idx)
         1:                 return ctrl_rst;
         2:                 return 8'h7F;
         3, 4, 5, 10, 14:   return 8'hFF;
         default:           return 8'h00;
      endcase
   endfunction

   function automatic bit reg_host_wr(input int idx);
      return !(idx == 0 || idx == 8 || idx == 9 || idx == 12 || idx == 13);
   endfunction

   function automatic bit reg_meas_wr(input int idx);
      return !(idx == 0 || idx == 1);
   endfunction
endpackage

// File: rtl/gg_line_sync.sv
module gg_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("gg_line_sync: STAGES must be 2..4");
   end

   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s    = scl_pipe[STAGES-1];
   assign sda_s    = sda_pipe[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/gg_regmap.sv
module gg_regmap
   import gg_pkg::*;
#(
   parameter logic [7:0] CTRL_RST = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              meas_we,
   input  logic [IDX_W-1:0]  meas_addr,
   input  logic [7:0]        meas_wdata,
   input  logic [STAT_W-1:0] stat_cond,
   input  logic              stat_clr,
   input  logic              ara_done,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [7:0]        rd_data,
   output logic [7:0]        ctrl,
   output logic              alert_on
);
   logic [NREG-1:0][7:0] map;
   logic [STAT_W-1:0]    stat_q;
   logic                 pend_q, new_evt;

   assign map[0] = {{(8-STAT_W){1'b0}}, stat_q};

   for (genvar a = 1; a < NREG; a++) begin : g_reg
      localparam logic [7:0] RST = reg_rst_val(a, CTRL_RST);
      logic [7:0] q;
      logic       hw_hit, mw_hit;
      if (reg_host_wr(a)) begin : g_hw
         assign hw_hit = host_we && (host_addr == IDX_W'(a));
      end else begin : g_nohw
         assign hw_hit = 1'b0;
      end
      if (reg_meas_wr(a)) begin : g_mw
         assign mw_hit = meas_we && (meas_addr == IDX_W'(a));
      end else begin : g_nomw
         assign mw_hit = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q <= RST;
         else if (hw_hit) q <= host_wdata;
         else if (mw_hit) q <= meas_wdata;
      end
      assign map[a] = q;
   end

   assign new_evt = |(stat_cond & ~stat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= 1'b0;
      end else begin
         stat_q <= stat_clr ? stat_cond : (stat_q | stat_cond);
         pend_q <= (pend_q & ~ara_done) | new_evt;
      end
   end

   assign rd_data  = map[rd_addr];
   assign ctrl     = map[1];
   assign alert_on = pend_q && (map[1][2:1] == 2'b10);

   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   a_r7_cond_kept: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr |=> ((stat_q & $past(stat_cond)) == $past(stat_cond)));
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (ara_done && !new_evt) |=> !alert_on);
   a_r5_volt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_we |=> $stable(map[8]));
endmodule

// File: rtl/i2c_gauge_slave.sv
module i2c_gauge_slave
   import gg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'h64,
   parameter logic [6:0] ARA_ADDR    = 7'h0C,
   parameter logic [7:0] CTRL_RST    = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic              alert_pull_o,
   input  logic [STAT_W-1:0] stat_cond_i,
   input  logic              meas_we_i,
   input  logic [IDX_W-1:0]  meas_addr_i,
   input  logic [7:0]        meas_data_i,
   output logic [7:0]        ctrl_o
);
   if (DEV_ADDR == ARA_ADDR) begin : g_bad_addr
      $error("i2c_gauge_slave: device and alert response addresses collide");
   end

   logic sda_s, scl_rise, scl_fall, start_p, stop_p;
   gg_state_e st, nxt;
   logic [3:0] cnt;
   logic [7:0] sh, tx, rd_data;
   logic [IDX_W-1:0] ptr, rd_addr;
   logic ptr_ok, ara, mack, alert_on;
   logic host_we, stat_clr, ara_done, lost, load_now;

   gg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p));

   always_comb begin
      rd_addr  = (st == ST_MACK) ? ptr + 1'b1 : ptr;
      load_now = scl_fall && ((st == ST_ACK && nxt == ST_TX && !ara) ||
                              (st == ST_MACK && mack));
      stat_clr = load_now && (rd_addr == '0);
      host_we  = scl_fall && st == ST_RXD && cnt == 4'd8 && ptr_ok;
      ara_done = scl_fall && st == ST_TX && ara && cnt == 4'd7;
      lost     = scl_rise && st == ST_TX && ara && tx[7] && !sda_s;
   end

   gg_regmap #(.CTRL_RST(CTRL_RST)) u_map (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(ptr), .host_wdata(sh),
      .meas_we(meas_we_i), .meas_addr(meas_addr_i), .meas_wdata(meas_data_i),
      .stat_cond(stat_cond_i), .stat_clr(stat_clr), .ara_done(ara_done),
      .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl_o), .alert_on(alert_on));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; sh <= '0; tx <= '1;
         ptr <= '0; ptr_ok <= 1'b0; ara <= 1'b0; mack <= 1'b0;
      end else if (start_p) begin
         st <= ST_ADDR; cnt <= '0; ara <= 1'b0;
      end else if (stop_p) begin
         st <= ST_IDLE;
      end else begin
         case (st)
            ST_ADDR, ST_RXD: begin
               if (scl_rise && cnt < 4'd8) begin
                  sh  <= {sh[6:0], sda_s};
                  cnt <= cnt + 1'b1;
               end else if (scl_fall && cnt == 4'd8) begin
                  if (st == ST_RXD) begin
                     if (!ptr_ok) begin
                        ptr <= sh[IDX_W-1:0]; ptr_ok <= 1'b1;
                     end else begin
                        ptr <= ptr + 1'b1;
                     end
                     st <= ST_ACK; nxt <= ST_RXD;
                  end else if (sh[7:1] == DEV_ADDR) begin
                     st <= ST_ACK;
                     nxt <= sh[0] ? ST_TX : ST_RXD;
                     if (!sh[0]) ptr_ok <= 1'b0;
                  end else if (sh == {ARA_ADDR, 1'b1} && alert_on) begin
                     st <= ST_ACK; nxt <= ST_TX; ara <= 1'b1;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_ACK: if (scl_fall) begin
               st  <= nxt;
               cnt <= '0;
               if (nxt == ST_TX) tx <= ara ? {DEV_ADDR, 1'b1} : rd_data;
            end
            ST_TX: begin
               if (lost) begin
                  st <= ST_IDLE;
               end else if (scl_fall) begin
                  tx  <= {tx[6:0], 1'b1};
                  cnt <= cnt + 1'b1;
                  if (cnt == 4'd7) st <= ara ? ST_IDLE : ST_MACK;
               end
            end
            ST_MACK: begin
               if (scl_rise) mack <= !sda_s;
               if (scl_fall) begin
                  if (mack) begin
                     ptr <= ptr + 1'b1; tx <= rd_data; cnt <= '0; st <= ST_TX;
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sda_pull_o   = (st == ST_ACK) || (st == ST_TX && !tx[7]);
   assign alert_pull_o = alert_on;

   a_r12_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_p && !start_p) |=> !sda_pull_o);
   a_r10_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
      (lost && !start_p && !stop_p) |=> (!sda_pull_o && st == ST_IDLE));
   a_r11_ara_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && scl_fall && cnt == 4'd8 && !start_p && !stop_p &&
       sh == {ARA_ADDR, 1'b1} && !alert_on) |=> (st == ST_IDLE));
   a_r3_nak_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MACK && scl_fall && !mack && !start_p && !stop_p) |=> !sda_pull_o);
endmodule

// File: tb/i2c_gauge_slave_tb.sv
module i2c_gauge_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, comp = 1'b0;
   logic sda_pull, alert_pull;
   logic [5:0] cond = '0;
   logic meas_we = 1'b0;
   logic [3:0] meas_addr = '0;
   logic [7:0] meas_data = '0;
   logic [7:0] ctrl;
   wire sda_line = sda_m & ~sda_pull & ~comp;

   int checks = 0, errors = 0;
   logic [7:0] expv [16];
   logic [5:0] stat_exp = '0;
   logic [7:0] rbuf [20];
   logic [7:0] wbuf [20];
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_gauge_slave dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .alert_pull_o(alert_pull), .stat_cond_i(cond),
      .meas_we_i(meas_we), .meas_addr_i(meas_addr), .meas_data_i(meas_data),
      .ctrl_o(ctrl));

   function automatic bit host_wr(input int a);
      return !(a == 0 || a == 8 || a == 9 || a == 12 || a == 13);
   endfunction

   function automatic logic [7:0] rst_val(input int a);
      if (a == 1) return 8'h3C;
      if (a == 2) return 8'h7F;
      if (a == 3 || a == 4 || a == 5 || a == 10 || a == 14) return 8'hFF;
      return 8'h00;
   endfunction

   task automatic w(input int n); repeat (n) @(negedge clk); endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_start;
      w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0;
   endtask

   task automatic bus_stop;
      w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         w(Q); sda_m = b[i]; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0;
      end
      w(Q); sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); ack = !sda_line; w(Q); scl_m = 1'b0;
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit mack, input bit c);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         w(Q); sda_m = 1'b1; comp = c; w(Q); scl_m = 1'b1; w(Q);
         b = {b[6:0], sda_line}; w(Q); scl_m = 1'b0;
      end
      w(Q); comp = 1'b0; sda_m = mack ? 1'b0 : 1'b1; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0;
   endtask

   task automatic write_regs(input logic [3:0] p, input int n, input string req);
      logic ack;
      bus_start;
      send_byte(8'hC8, ack); chk({req, " R1 write addr ack"}, {7'd0, ack}, 8'd1);
      send_byte({4'd0, p}, ack);
      for (int i = 0; i < n; i++) send_byte(wbuf[i], ack);
      bus_stop;
   endtask

   task automatic read_regs(input logic [3:0] p, input int n);
      logic ack;
      bus_start;
      send_byte(8'hC8, ack);
      send_byte({4'd0, p}, ack);
      bus_start;
      send_byte(8'hC9, ack); chk("R3 read addr ack", {7'd0, ack}, 8'd1);
      for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1, 1'b0);
      bus_stop;
      chk("R3 R12 SDA released after NAK and STOP", {7'd0, sda_pull}, 8'd0);
   endtask

   task automatic pulse_cond(input logic [5:0] v);
      cond = v; w(1); cond = '0; w(3);
      stat_exp = stat_exp | v;
   endtask

   task automatic read_all(input string req);
      read_regs(4'd0, 17);
      expv[0] = {2'b00, stat_exp};
      for (int i = 0; i < 17; i++) chk(req, rbuf[i], expv[i % 16]);
      stat_exp = stat_exp & cond;
   endtask

   task automatic ara(input bit c, output logic ack, output logic [7:0] b);
      bus_start;
      send_byte(8'h19, ack);
      if (ack) recv_byte(b, 1'b0, c);
      else b = 8'hxx;
      bus_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] b;
      void'($urandom(32'd5150));
      for (int i = 0; i < 16; i++) expv[i] = rst_val(i);
      w(4); rst_n = 1'b1; w(4);

      chk("R4 reset ctrl_o", ctrl, 8'h3C);
      chk("R8 reset alert released", {7'd0, alert_pull}, 8'd0);
      chk("R12 reset SDA released", {7'd0, sda_pull}, 8'd0);

      // R4 R3: reset map read back, 17 bytes so the read pointer wraps
      read_all("R4 R3 reset map");

      // R1: foreign address
      bus_start; send_byte(8'hA0, ack); bus_stop;
      chk("R1 foreign address not acked", {7'd0, ack}, 8'd0);

      // R2 R5: directed write crossing the 15->0 wrap
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h50 + 8'(i);
      write_regs(4'd14, 4, "R2 wrap");
      for (int i = 0; i < 4; i++) if (host_wr((14 + i) % 16)) expv[(14 + i) % 16] = wbuf[i];
      read_all("R2 R5 wrap write");
      chk("R2 ctrl_o after write", ctrl, expv[1]);

      // R2 R5: random writes
      for (int r = 0; r < 4; r++) begin
         logic [3:0] p;
         int n;
         p = 4'($urandom);
         n = 2 + int'($urandom % 5);
         for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
         write_regs(p, n, "R2 random");
         for (int i = 0; i < n; i++) if (host_wr((p + i) % 16)) expv[(p + i) % 16] = wbuf[i];
      end
      read_all("R2 R5 random writes");

      // restore control to alert mode
      wbuf[0] = 8'h3C; write_regs(4'd1, 1, "R8 ctrl restore"); expv[1] = 8'h3C;

      // R5: measurement port loads protected indices, host writes bounce off
      meas_addr = 4'd8; meas_data = 8'hB0; meas_we = 1'b1; w(1);
      meas_addr = 4'd13; meas_data = 8'h40; w(1); meas_we = 1'b0; w(2);
      expv[8] = 8'hB0; expv[13] = 8'h40;
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      write_regs(4'd8, 2, "R5 protected");
      read_regs(4'd8, 1); chk("R5 index 8 holds measurement", rbuf[0], 8'hB0);
      read_regs(4'd13, 1); chk("R5 index 13 holds measurement", rbuf[0], 8'h40);

      // R6 R8: status set by condition pulse raises alert
      pulse_cond(6'b001000);
      chk("R8 alert after new status", {7'd0, alert_pull}, 8'd1);
      read_regs(4'd0, 1); chk("R6 status read", rbuf[0], 8'h08);
      stat_exp = stat_exp & cond;
      read_regs(4'd0, 1); chk("R7 status cleared after read", rbuf[0], 8'h00);
      chk("R8 alert stays after status read", {7'd0, alert_pull}, 8'd1);

      // R7: held condition survives the read
      cond = 6'b000010; w(3);
      read_regs(4'd0, 1); chk("R7 held bit read", rbuf[0], 8'h02);
      read_regs(4'd0, 1); chk("R7 held bit survives read", rbuf[0], 8'h02);
      cond = '0; w(2);
      read_regs(4'd0, 1); chk("R7 bit held until read after drop", rbuf[0], 8'h02);
      read_regs(4'd0, 1); chk("R7 bit clears once dropped", rbuf[0], 8'h00);
      stat_exp = '0;

      // R10: lose arbitration against a lower-addressed device
      ara(1'b1, ack, b);
      chk("R9 alert response acked", {7'd0, ack}, 8'd1);
      chk("R10 competitor byte seen", b, 8'h00);
      chk("R10 alert kept after loss", {7'd0, alert_pull}, 8'd1);

      // R9: winning alert response
      ara(1'b0, ack, b);
      chk("R9 alert response acked", {7'd0, ack}, 8'd1);
      chk("R9 reply byte", b, 8'hC9);
      chk("R9 alert released", {7'd0, alert_pull}, 8'd0);

      // R11: no alert pending
      ara(1'b0, ack, b);
      chk("R11 alert response not acked", {7'd0, ack}, 8'd0);

      // R8: mode gating of the alert pin
      wbuf[0] = 8'h38; write_regs(4'd1, 1, "R8 disabled mode");
      pulse_cond(6'b100000);
      chk("R8 no alert in disabled mode", {7'd0, alert_pull}, 8'd0);
      wbuf[0] = 8'h3A; write_regs(4'd1, 1, "R8 input mode");
      chk("R8 no alert in charge-complete mode", {7'd0, alert_pull}, 8'd0);
      wbuf[0] = 8'h3C; write_regs(4'd1, 1, "R8 alert mode");
      chk("R8 pending alert shows in alert mode", {7'd0, alert_pull}, 8'd1);
      ara(1'b0, ack, b);
      chk("R9 second reply byte", b, 8'hC9);
      chk("R9 second release", {7'd0, alert_pull}, 8'd0);

      // R12: STOP in the middle of a write, then a fresh transfer works
      bus_start; send_byte(8'hC8, ack); send_byte(8'h04, ack); bus_stop;
      chk("R12 idle after STOP", {7'd0, sda_pull}, 8'd0);
      read_regs(4'd4, 1); chk("R12 R3 read after aborted write", rbuf[0], expv[4]);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule